// File: doc/BRIEF.md
# Island ID Address Decoder

This block works out which destination island a bus address will reach. It takes the address, the target code of the access and the translation configuration word that belongs to that target. From the translation mode in that word it builds a 6-bit island ID. The ID can come straight from an address field. It can also be one of two configured base islands, picked by an index bit in the address. In the last two modes it is a base island with its low bits replaced by the address bits that sit just below the index bit. Both a 32-bit and a 40-bit address layout are supported, and the layout moves the index bit and the island field.

The result is registered. One clock after an input strobe the block presents the island, an error flag and a one-cycle output-valid pulse. An unsupported mode raises the error flag. So does either of the two targets this decoder does not handle (the memory-unit target and the cross-bar-peripheral target). Whenever the error flag is set, the island output is zero. The configuration table that supplies the word is kept elsewhere.

Top module: `isld_decoder`

## Requirements
- R1: The configuration word is split as follows. Bits [5:0] hold base island 0 and bits [11:6] hold base island 1. Bit 12 set selects the 40-bit layout and bit 12 clear selects the 32-bit layout. Bits [15:13] hold the mode.
- R2: In mode 0 the island is address bits [39:34] in the 40-bit layout, or bits [31:26] in the 32-bit layout.
- R3: In mode 1 the index bit decides the island. The index bit is address bit 39 in the 40-bit layout and bit 31 in the 32-bit layout. When the index bit is 1 the island is base island 1; when it is 0 the island is base island 0.
- R4: In mode 2 the base island picked by the index bit supplies bits [5:1] of the island. Island bit 0 is the address bit one position below the index bit.
- R5: In mode 3 the base island picked by the index bit supplies bits [5:2] of the island. Island bits [1:0] are the two address bits directly below the index bit, with the higher of those two as island bit 1.
- R6: A mode value of 4 to 7 sets the error flag.
- R7: Target code 7 (memory unit) and target code 14 (cross-bar peripheral) set the error flag whatever the mode is.
- R8: A strobe on `in_valid` gives `out_valid` high, together with that input's island and error, on the next clock edge. When no strobe was sampled, `out_valid` is low.
- R9: While the error flag is set, the island output is 0.
- R10: A synchronous active-high reset clears `out_valid`, even when a strobe is present in the same cycle.
- R11: With no strobe, the island and error outputs keep the values of the last decoded input, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_addr | input | 40 | Bus address |
| in_target | input | 4 | Target code |
| in_cfg | input | 16 | Translation configuration word for the target |
| out_valid | output | 1 | Result-valid pulse, one clock after the strobe |
| out_island | output | 6 | Decoded destination island |
| out_err | output | 1 | Decode error |

## Verification
The bench aims at these corner cases:
- **Index-bit position in both layouts.** A design that reads bit 31 when the 40-bit flag is set picks the wrong base island.
- **Address bits below the index bit in modes 2 and 3.** A design that swaps them, or shifts them by one, produces islands whose low bits disagree.
- **Base island low bits.** The base islands are set with their low bits at 1. If mode 2 or 3 forgot to clear those bits, the OR would show through as extra set bits.
- **Errors.** Bad modes and the two rejected targets are mixed with otherwise valid words. A design that leaves the decoded island on the output when the error flag is set would be caught.
- **Reset during a strobe, and idle cycles with changing inputs.** These expose a result register that updates without a strobe or that ignores reset.

// File: rtl/isld_pkg.sv
package isld_pkg;
  localparam int ISLD_W = 6;
  localparam int CFG_W  = 16;

  typedef struct packed {
    logic [2:0]        mode;
    logic              wide;
    logic [ISLD_W-1:0] base1;
    logic [ISLD_W-1:0] base0;
  } isld_cfg_t;

  typedef enum logic [2:0] {
    XL_FIELD = 3'd0,
    XL_PICK  = 3'd1,
    XL_MIX1  = 3'd2,
    XL_MIX2  = 3'd3
  } xl_mode_e;

  // keep the upper bits of a base island and fill the lowest nlow bits from low
  function automatic logic [ISLD_W-1:0] merge_low(input logic [ISLD_W-1:0] base,
                                                  input logic [1:0] low,
                                                  input int unsigned nlow);
    logic [ISLD_W-1:0] keep;
    keep = {ISLD_W{1'b1}} << nlow;
    return (base & keep) | ({{(ISLD_W-2){1'b0}}, low} & ~keep);
  endfunction

  function automatic logic mode_is_bad(input logic [2:0] mode);
    return mode > 3'd3;
  endfunction
endpackage

// File: rtl/isld_cfg_unpack.sv
module isld_cfg_unpack
  import isld_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output isld_cfg_t        cfg,
  output logic             mode_bad
);
  assign cfg      = isld_cfg_t'(cfg_word);
  assign mode_bad = mode_is_bad(cfg.mode);
endmodule

// File: rtl/isld_addr_taps.sv
module isld_addr_taps #(
  parameter int ADDR_W     = 40,
  parameter int IDX_NARROW = 31,
  parameter int IDX_WIDE   = 39,
  parameter int FLD_NARROW = 26,
  parameter int FLD_WIDE   = 34,
  parameter int FLD_W      = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic [FLD_W-1:0]  field,
  output logic              idx_bit,
  output logic [1:0]        below_idx
);
  always_comb begin
    if (wide) begin
      field     = addr[FLD_WIDE +: FLD_W];
      idx_bit   = addr[IDX_WIDE];
      below_idx = addr[IDX_WIDE-1 -: 2];
    end else begin
      field     = addr[FLD_NARROW +: FLD_W];
      idx_bit   = addr[IDX_NARROW];
      below_idx = addr[IDX_NARROW-1 -: 2];
    end
  end
endmodule

// File: rtl/isld_mixer.sv
module isld_mixer
  import isld_pkg::*;
(
  input  isld_cfg_t         cfg,
  input  logic [ISLD_W-1:0] field,
  input  logic              idx_bit,
  input  logic [1:0]        below_idx,
  output logic [ISLD_W-1:0] island,
  output logic [ISLD_W-1:0] sel_base
);
  assign sel_base = idx_bit ? cfg.base1 : cfg.base0;

  always_comb begin
    unique case (cfg.mode)
      XL_FIELD: island = field;
      XL_PICK:  island = sel_base;
      XL_MIX1:  island = merge_low(sel_base, {1'b0, below_idx[1]}, 1);
      XL_MIX2:  island = merge_low(sel_base, below_idx, 2);
      default:  island = '0;
    endcase
  end
endmodule

// File: rtl/isld_decoder.sv
module isld_decoder
  import isld_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int TGT_W    = 4,
  parameter int TGT_MEM  = 7,
  parameter int TGT_XBAR = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TGT_W-1:0]  in_target,
  input  logic [CFG_W-1:0]  in_cfg,
  output logic              out_valid,
  output logic [ISLD_W-1:0] out_island,
  output logic              out_err
);
  isld_cfg_t         cfg;
  logic              mode_bad;
  logic [ISLD_W-1:0] field;
  logic              idx_bit;
  logic [1:0]        below_idx;
  logic [ISLD_W-1:0] island_raw;
  logic [ISLD_W-1:0] sel_base;
  logic              tgt_reject;
  logic              dec_err;

  isld_cfg_unpack u_cfg (
    .cfg_word (in_cfg),
    .cfg      (cfg),
    .mode_bad (mode_bad)
  );

  isld_addr_taps #(.ADDR_W(ADDR_W), .FLD_W(ISLD_W)) u_taps (
    .addr      (in_addr),
    .wide      (cfg.wide),
    .field     (field),
    .idx_bit   (idx_bit),
    .below_idx (below_idx)
  );

  isld_mixer u_mix (
    .cfg       (cfg),
    .field     (field),
    .idx_bit   (idx_bit),
    .below_idx (below_idx),
    .island    (island_raw),
    .sel_base  (sel_base)
  );

  assign tgt_reject = (in_target == TGT_WIDTH_MEM) || (in_target == TGT_WIDTH_XBAR);
  localparam logic [TGT_W-1:0] TGT_WIDTH_MEM  = TGT_W'(TGT_MEM);
  localparam logic [TGT_W-1:0] TGT_WIDTH_XBAR = TGT_W'(TGT_XBAR);
  assign dec_err = tgt_reject || mode_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_island <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err    <= dec_err;
        out_island <= dec_err ? '0 : island_raw;
      end
    end
  end

  p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> !out_valid);
  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_island == '0);
  p_bad_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cfg[15:13] > 3'd3) |=> out_err);
  p_tgt_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tgt_reject) |=> out_err);
  p_pick_base_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_err && cfg.mode == XL_PICK) |=>
      (out_island == $past(in_cfg[5:0]) || out_island == $past(in_cfg[11:6])));
  p_mix1_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dec_err && cfg.mode == XL_MIX1) |=>
      out_island[5:1] == $past(sel_base[5:1]));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> $stable(out_island) && $stable(out_err));
endmodule

// File: tb/isld_decoder_tb.sv
module isld_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [39:0] in_addr;
  logic [3:0]  in_target;
  logic [15:0] in_cfg;
  logic        out_valid;
  logic [5:0]  out_island;
  logic        out_err;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  logic [5:0] last_isl;
  logic       last_err;

  always #5 clk = ~clk;

  isld_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_target(in_target), .in_cfg(in_cfg), .out_valid(out_valid),
    .out_island(out_island), .out_err(out_err)
  );

  function automatic logic ref_err(logic [39:0] a, logic [3:0] t, logic [15:0] c);
    return (t == 4'd7) || (t == 4'd14) || (c[15] == 1'b1);
  endfunction

  function automatic logic [5:0] ref_isl(logic [39:0] a, logic [3:0] t, logic [15:0] c);
    int p;
    logic [5:0] b;
    if (ref_err(a, t, c)) return 6'd0;
    p = c[12] ? 39 : 31;
    b = ((a >> p) & 1) != 0 ? 6'((c >> 6) & 16'h3f) : 6'(c & 16'h3f);
    case (c[14:13])
      2'd0: return 6'((a >> (p - 5)) & 40'h3f);
      2'd1: return b;
      2'd2: return (b & 6'h3e) | 6'((a >> (p - 1)) & 40'h1);
      default: return (b & 6'h3c) | 6'((a >> (p - 2)) & 40'h3);
    endcase
  endfunction

  task automatic check(string req, logic [5:0] ai, logic [5:0] ei, logic ae, logic ee,
                       logic av, logic ev);
    vectors++;
    if (ai !== ei || ae !== ee || av !== ev) begin
      fails++;
      $display("FAIL %s: island=%0h err=%0b valid=%0b expected island=%0h err=%0b valid=%0b",
               req, ai, ae, av, ei, ee, ev);
    end
  endtask

  task automatic apply(logic [39:0] a, logic [3:0] t, logic [15:0] c, string req);
    logic [5:0] ei;
    logic ee;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_target = t; in_cfg = c;
    ei = ref_isl(a, t, c);
    ee = ref_err(a, t, c);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_island, ei, out_err, ee, out_valid, 1'b1);
    last_isl = ei; last_err = ee;
  endtask

  task automatic idle(string req);
    @(negedge clk);
    in_valid = 1'b0; in_addr = {$urandom, $urandom}; in_target = 4'($urandom);
    in_cfg = 16'($urandom);
    @(negedge clk);
    check(req, out_island, last_isl, out_err, last_err, out_valid, 1'b0);
  endtask

  function automatic logic [15:0] mk_cfg(int mode, bit wide, int b1, int b0);
    return {3'(mode), wide, 6'(b1), 6'(b0)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_target = '0; in_cfg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", out_island, 6'd0, out_err, 1'b0, out_valid, 1'b0);

    apply(40'h2A_0000_0000 << 2, 4'd1, mk_cfg(0, 1, 5, 9), "R2 R1 mode0 wide");
    apply(40'h00_B400_0000, 4'd2, mk_cfg(0, 0, 5, 9), "R2 mode0 narrow");
    apply(40'h80_0000_0000, 4'd3, mk_cfg(1, 1, 6'h31, 6'h0c), "R3 mode1 wide idx1");
    apply(40'h00_8000_0000, 4'd3, mk_cfg(1, 1, 6'h31, 6'h0c), "R3 mode1 wide idx0");
    apply(40'h00_8000_0000, 4'd0, mk_cfg(1, 0, 6'h31, 6'h0c), "R3 mode1 narrow idx1");
    apply(40'hC0_0000_0000, 4'd5, mk_cfg(2, 1, 6'h3f, 6'h01), "R4 mode2 wide");
    apply(40'h00_4000_0000, 4'd5, mk_cfg(2, 0, 6'h3f, 6'h15), "R4 mode2 narrow");
    apply(40'hA0_0000_0000, 4'd6, mk_cfg(3, 1, 6'h2f, 6'h13), "R5 mode3 wide");
    apply(40'h00_2000_0000, 4'd6, mk_cfg(3, 0, 6'h2f, 6'h13), "R5 mode3 narrow");
    apply(40'hFF_FFFF_FFFF, 4'd1, mk_cfg(5, 1, 6'h2f, 6'h13), "R6 R9 bad mode");
    idle("R11 hold after error");
    apply(40'h12_3456_789A, 4'd7, mk_cfg(1, 0, 6'h2f, 6'h13), "R7 R9 mem target");
    apply(40'h12_3456_789A, 4'd14, mk_cfg(0, 1, 6'h2f, 6'h13), "R7 R9 xbar target");
    apply(40'h80_0000_0000, 4'd2, mk_cfg(1, 1, 6'h2a, 6'h01), "R8 back to good");
    idle("R11 hold good result");
    idle("R8 no strobe no valid");

    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check("R10 reset over strobe", out_island, 6'd0, out_err, 1'b0, out_valid, 1'b0);
    last_isl = 6'd0; last_err = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] c;
      c = 16'($urandom);
      if (($urandom % 4) != 0) c[15] = 1'b0;
      apply({$urandom, $urandom}, 4'($urandom), c, "R2-5 random");
      if (($urandom % 8) == 0) idle("R11 random idle");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(1500000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule